// File: doc/BRIEF.md
# Adaptive Reed-Solomon Parity Selector

This block chooses how many Reed-Solomon parity symbols the transmitter attaches to each code block of the frames it sends next. After each frame, the link layer gives it a short report with three numbers: how many fragments the frame carried, how many of them the far end received intact, and how many symbols the receiver's decoder had to repair. The block adds these reports up over a fixed window of frames. At the end of each window it makes one decision: use more parity, use less parity, or keep the current amount.

Each available setting has a code rate of (255-p)/255, where p is the parity count, and that rate also acts as the setting's loss threshold. If the fraction of fragments that arrived falls below the code rate of the current setting, losses are costing more throughput than extra parity would. The block then moves to the next stronger code. It moves to lighter coding only when a window lost no fragment at all and the decoder used little of its correction capability. The chosen parity count is held on an output bus, and a one-cycle strobe marks every change so the encoder and the frame header logic can pick up the new value.

Top module: `fec_redundancy_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `parity_syms` is 18 and `parity_upd` is 0 until the first decision.
- R2: A report is taken only in a cycle with `stat_valid` high; cycles with `stat_valid` low have no effect on the sums, whatever the data inputs hold. A decision is made once per 16 reports taken. Its result appears on the outputs in the second cycle after the clock edge that took the 16th report.
- R3: With p the current parity count, the block moves to p+2 when 256·OK < (255-p)·SENT. Here SENT and OK are the window's totals of fragments sent and fragments delivered. (255-p)/256 is the 8-bit form of the code rate.
- R4: When the window has SENT > 0 and OK = SENT, and also 8·CORR ≤ p·SENT (CORR is the window's total of corrected symbols, one code block per fragment), the block moves to p-2. In words: the average number of corrections per block is at most a quarter of the correction capability p/2.
- R5: In all other cases the parity count stays the same. This covers partial loss at or above the threshold of R3, and loss-free windows whose corrections exceed the limit of R4.
- R6: A decision changes the parity count by at most 2.
- R7: The parity count stays within 2..18 and is always even. An increase at 18 and a decrease at 2 leave it unchanged.
- R8: `parity_upd` is high for exactly one cycle, in the same cycle that a new parity count first appears, and only when the count has actually changed.
- R9: A report whose delivered count is larger than its sent count is counted as if delivered equalled sent.
- R10: A window in which no fragments were sent leaves the parity count unchanged.
- R11: A report taken on the clock edge that applies a decision is counted as the first report of the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_valid | input | 1 | Per-frame report is present this cycle |
| stat_sent | input | 8 | Fragments sent in the frame |
| stat_ok | input | 8 | Fragments delivered intact |
| stat_corr | input | 10 | Symbols corrected across the frame's blocks |
| parity_syms | output | 5 | Selected parity symbols per RS block (2..18) |
| parity_upd | output | 1 | One-cycle pulse when `parity_syms` changes |

## Verification
The bench puts the delivered total exactly on the threshold and one fragment below it. A design that uses ≤ where < is meant, or that rounds the code rate wrongly, would raise the parity count one window too early. The bench also puts the corrected-symbol total exactly on its limit and one above it, and adds windows with no fragments, windows where delivered exceeds sent, and runs that drive the count into both ends. A design that gets these wrong would step down after an empty window, let an over-reported delivery hide a loss, or leave the even range 2..18. Reports sent back-to-back with no gap between windows catch a design that drops or double-counts the report taken on the decision edge. Idle cycles that carry junk data catch a design that does not gate its sums on `stat_valid`.

// File: rtl/fec_rc_pkg.sv
package fec_rc_pkg;

  typedef enum logic [1:0] {
    DEC_HOLD = 2'd0,
    DEC_UP   = 2'd1,
    DEC_DOWN = 2'd2
  } fec_dec_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/fec_win_accum.sv
module fec_win_accum #(
  parameter int unsigned FRAG_W     = 8,
  parameter int unsigned ERR_W      = 10,
  parameter int unsigned WIN_FRAMES = 16,
  localparam int unsigned CNT_W     = $clog2(WIN_FRAMES),
  localparam int unsigned SUM_W     = FRAG_W + CNT_W,
  localparam int unsigned CSUM_W    = ERR_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_valid,
  input  logic [FRAG_W-1:0] stat_sent,
  input  logic [FRAG_W-1:0] stat_ok,
  input  logic [ERR_W-1:0]  stat_corr,
  output logic [SUM_W-1:0]  sent_sum,
  output logic [SUM_W-1:0]  ok_sum,
  output logic [CSUM_W-1:0] corr_sum,
  output logic              eval_req
);

  logic [CNT_W-1:0]  cnt_q, cnt_base, cnt_d;
  logic [SUM_W-1:0]  sent_base, ok_base, sent_d, ok_d;
  logic [CSUM_W-1:0] corr_base, corr_d;
  logic [FRAG_W-1:0] ok_eff;
  logic              eval_d;

  // delivered count never exceeds sent count
  assign ok_eff = (stat_ok > stat_sent) ? stat_sent : stat_ok;

  always_comb begin
    // a decision cycle consumes the sums; a report in it opens the next window
    cnt_base  = eval_req ? '0 : cnt_q;
    sent_base = eval_req ? '0 : sent_sum;
    ok_base   = eval_req ? '0 : ok_sum;
    corr_base = eval_req ? '0 : corr_sum;
    cnt_d     = cnt_base;
    sent_d    = sent_base;
    ok_d      = ok_base;
    corr_d    = corr_base;
    eval_d    = 1'b0;
    if (stat_valid) begin
      sent_d = sent_base + SUM_W'(stat_sent);
      ok_d   = ok_base + SUM_W'(ok_eff);
      corr_d = corr_base + CSUM_W'(stat_corr);
      if (cnt_base == CNT_W'(WIN_FRAMES - 1)) begin
        cnt_d  = '0;
        eval_d = 1'b1;
      end else begin
        cnt_d = cnt_base + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      sent_sum <= '0;
      ok_sum   <= '0;
      corr_sum <= '0;
      eval_req <= 1'b0;
    end else begin
      eval_req <= eval_d;
      if (stat_valid || eval_req) begin
        cnt_q    <= cnt_d;
        sent_sum <= sent_d;
        ok_sum   <= ok_d;
        corr_sum <= corr_d;
      end
    end
  end

endmodule

// File: rtl/fec_mode_decide.sv
module fec_mode_decide #(
  parameter int unsigned NUM_MODES   = 9,
  parameter int unsigned PAR_MIN     = 2,
  parameter int unsigned PAR_STEP    = 2,
  parameter int unsigned CODE_N      = 255,
  parameter int unsigned RATE_FRAC_W = 8,
  parameter int unsigned DOWN_SHIFT  = 3,
  parameter int unsigned MODE_W      = 4,
  parameter int unsigned PAR_W       = 5,
  parameter int unsigned SUM_W       = 12,
  parameter int unsigned CSUM_W      = 14,
  localparam int unsigned CMP_W      = fec_rc_pkg::max3(SUM_W + RATE_FRAC_W,
                                         CSUM_W + DOWN_SHIFT, PAR_W + SUM_W) + 1
) (
  input  logic [MODE_W-1:0]        mode_idx,
  input  logic [SUM_W-1:0]         sent_sum,
  input  logic [SUM_W-1:0]         ok_sum,
  input  logic [CSUM_W-1:0]        corr_sum,
  output fec_rc_pkg::fec_dec_e     decision
);

  logic [RATE_FRAC_W-1:0] rate_tab [NUM_MODES];
  logic [PAR_W-1:0]       par_tab  [NUM_MODES];

  // per-mode parity count and code rate as a fraction of 2^RATE_FRAC_W
  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    localparam int unsigned P_M    = PAR_MIN + m * PAR_STEP;
    localparam int unsigned RATE_M = ((CODE_N - P_M) << RATE_FRAC_W) / CODE_N;
    assign rate_tab[m] = RATE_FRAC_W'(RATE_M);
    assign par_tab[m]  = PAR_W'(P_M);
  end

  logic [RATE_FRAC_W-1:0] rate_sel;
  logic [PAR_W-1:0]       par_sel;
  logic [CMP_W-1:0]       up_lhs, up_rhs, dn_lhs, dn_rhs;
  logic                   lossy, all_ok, light_corr;

  always_comb begin
    rate_sel   = rate_tab[mode_idx];
    par_sel    = par_tab[mode_idx];
    up_lhs     = CMP_W'(ok_sum) << RATE_FRAC_W;
    up_rhs     = CMP_W'(rate_sel) * CMP_W'(sent_sum);
    dn_lhs     = CMP_W'(corr_sum) << DOWN_SHIFT;
    dn_rhs     = CMP_W'(par_sel) * CMP_W'(sent_sum);
    lossy      = up_lhs < up_rhs;
    all_ok     = (sent_sum != '0) && (ok_sum == sent_sum);
    light_corr = dn_lhs <= dn_rhs;
    if (lossy)                    decision = fec_rc_pkg::DEC_UP;
    else if (all_ok && light_corr) decision = fec_rc_pkg::DEC_DOWN;
    else                          decision = fec_rc_pkg::DEC_HOLD;
  end

endmodule

// File: rtl/fec_mode_reg.sv
module fec_mode_reg #(
  parameter int unsigned NUM_MODES = 9,
  parameter int unsigned MODE_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 eval_req,
  input  fec_rc_pkg::fec_dec_e decision,
  output logic [MODE_W-1:0]    mode_idx,
  output logic                 upd_stb
);

  localparam logic [MODE_W-1:0] MODE_TOP = MODE_W'(NUM_MODES - 1);

  logic [MODE_W-1:0] mode_d;
  logic              stb_d;

  always_comb begin
    mode_d = mode_idx;
    if (eval_req) begin
      unique case (decision)
        fec_rc_pkg::DEC_UP:   if (mode_idx != MODE_TOP) mode_d = mode_idx + 1'b1;
        fec_rc_pkg::DEC_DOWN: if (mode_idx != '0)       mode_d = mode_idx - 1'b1;
        default:              mode_d = mode_idx;
      endcase
    end
    stb_d = mode_d != mode_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_idx <= MODE_TOP;
      upd_stb  <= 1'b0;
    end else begin
      upd_stb <= stb_d;
      if (eval_req) mode_idx <= mode_d;
    end
  end

endmodule

// File: rtl/fec_redundancy_ctrl.sv
module fec_redundancy_ctrl #(
  parameter int unsigned FRAG_W      = 8,
  parameter int unsigned ERR_W       = 10,
  parameter int unsigned WIN_FRAMES  = 16,
  parameter int unsigned NUM_MODES   = 9,
  parameter int unsigned PAR_MIN     = 2,
  parameter int unsigned PAR_STEP    = 2,
  parameter int unsigned CODE_N      = 255,
  parameter int unsigned RATE_FRAC_W = 8,
  localparam int unsigned PAR_MAX    = PAR_MIN + (NUM_MODES - 1) * PAR_STEP,
  localparam int unsigned PAR_W      = $clog2(PAR_MAX + 1),
  localparam int unsigned MODE_W     = $clog2(NUM_MODES),
  localparam int unsigned CNT_W      = $clog2(WIN_FRAMES),
  localparam int unsigned SUM_W      = FRAG_W + CNT_W,
  localparam int unsigned CSUM_W     = ERR_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_valid,
  input  logic [FRAG_W-1:0] stat_sent,
  input  logic [FRAG_W-1:0] stat_ok,
  input  logic [ERR_W-1:0]  stat_corr,
  output logic [PAR_W-1:0]  parity_syms,
  output logic              parity_upd
);

  logic [SUM_W-1:0]     sent_sum, ok_sum;
  logic [CSUM_W-1:0]    corr_sum;
  logic                 eval_req;
  logic [MODE_W-1:0]    mode_idx;
  fec_rc_pkg::fec_dec_e decision;

  fec_win_accum #(
    .FRAG_W(FRAG_W), .ERR_W(ERR_W), .WIN_FRAMES(WIN_FRAMES)
  ) u_accum (
    .clk(clk), .rst_n(rst_n),
    .stat_valid(stat_valid), .stat_sent(stat_sent),
    .stat_ok(stat_ok), .stat_corr(stat_corr),
    .sent_sum(sent_sum), .ok_sum(ok_sum), .corr_sum(corr_sum),
    .eval_req(eval_req)
  );

  fec_mode_decide #(
    .NUM_MODES(NUM_MODES), .PAR_MIN(PAR_MIN), .PAR_STEP(PAR_STEP),
    .CODE_N(CODE_N), .RATE_FRAC_W(RATE_FRAC_W), .DOWN_SHIFT(3),
    .MODE_W(MODE_W), .PAR_W(PAR_W), .SUM_W(SUM_W), .CSUM_W(CSUM_W)
  ) u_decide (
    .mode_idx(mode_idx), .sent_sum(sent_sum), .ok_sum(ok_sum),
    .corr_sum(corr_sum), .decision(decision)
  );

  fec_mode_reg #(
    .NUM_MODES(NUM_MODES), .MODE_W(MODE_W)
  ) u_mode (
    .clk(clk), .rst_n(rst_n), .eval_req(eval_req), .decision(decision),
    .mode_idx(mode_idx), .upd_stb(parity_upd)
  );

  assign parity_syms = PAR_W'(PAR_MIN + int'(mode_idx) * PAR_STEP);

endmodule

// File: rtl/fec_redundancy_ctrl_chk.sv
module fec_redundancy_ctrl_chk #(
  parameter int unsigned WIN_FRAMES = 16,
  parameter int unsigned PAR_MIN    = 2,
  parameter int unsigned PAR_MAX    = 18,
  parameter int unsigned PAR_STEP   = 2,
  parameter int unsigned PAR_W      = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stat_valid,
  input logic [PAR_W-1:0] parity_syms,
  input logic             parity_upd
);

  logic [$clog2(WIN_FRAMES)-1:0] frm_cnt;
  logic                          win_end_d1, win_end_d2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_cnt    <= '0;
      win_end_d1 <= 1'b0;
      win_end_d2 <= 1'b0;
    end else begin
      win_end_d1 <= stat_valid && (int'(frm_cnt) == WIN_FRAMES - 1);
      win_end_d2 <= win_end_d1;
      if (stat_valid) frm_cnt <= (int'(frm_cnt) == WIN_FRAMES - 1) ? '0 : frm_cnt + 1'b1;
    end
  end

  p_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(parity_syms) >= PAR_MIN) && (int'(parity_syms) <= PAR_MAX) && !parity_syms[0]);

  p_one_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (parity_syms != $past(parity_syms)) |->
      ((int'(parity_syms) == int'($past(parity_syms)) + PAR_STEP) ||
       (int'(parity_syms) + PAR_STEP == int'($past(parity_syms)))));

  p_strobe_on_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    parity_upd == (parity_syms != $past(parity_syms)));

  p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    parity_upd |=> !parity_upd);

  p_change_at_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    parity_upd |-> win_end_d2);

endmodule

bind fec_redundancy_ctrl fec_redundancy_ctrl_chk #(
  .WIN_FRAMES(WIN_FRAMES), .PAR_MIN(PAR_MIN), .PAR_MAX(PAR_MAX),
  .PAR_STEP(PAR_STEP), .PAR_W(PAR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .stat_valid(stat_valid),
  .parity_syms(parity_syms), .parity_upd(parity_upd)
);

// File: tb/fec_redundancy_ctrl_bench.sv
module fec_redundancy_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stat_valid = 1'b0;
  logic [7:0] stat_sent = '0;
  logic [7:0] stat_ok = '0;
  logic [9:0] stat_corr = '0;
  logic [4:0] parity_syms;
  logic       parity_upd;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int w_sent [16];
  int w_ok   [16];
  int w_corr [16];
  int cur_p = 18;
  int pend_p, pend_old;
  bit pending = 0;
  string pend_tag;

  always #2.5 clk = ~clk;

  fec_redundancy_ctrl u_fec_redundancy_ctrl (
    .clk(clk), .rst_n(rst_n), .stat_valid(stat_valid),
    .stat_sent(stat_sent), .stat_ok(stat_ok), .stat_corr(stat_corr),
    .parity_syms(parity_syms), .parity_upd(parity_upd)
  );

  // expected next parity from window totals (R3, R4, R5, R7, R10)
  function automatic int exp_next(input int p, input int s, input int o, input int c);
    if (o * 256 < (255 - p) * s) return (p < 18) ? p + 2 : p;
    if (s > 0 && o == s && c * 8 <= p * s) return (p > 2) ? p - 2 : p;
    return p;
  endfunction

  task automatic chk(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  task automatic idle_cycle();
    stat_valid = 1'b0;
    stat_sent  = 8'($urandom);   // junk while invalid: R2
    stat_ok    = 8'($urandom);
    stat_corr  = 10'($urandom);
    @(negedge clk);
  endtask

  task automatic send_frame(input int s, input int o, input int c);
    stat_valid = 1'b1;
    stat_sent  = 8'(s);
    stat_ok    = 8'(o);
    stat_corr  = 10'(c);
    @(negedge clk);
  endtask

  // R2/R8: new value and strobe in the second cycle after the 16th report
  task automatic check_pending();
    chk(int'(parity_syms), pend_p, {pend_tag, " R2 parity"});
    chk(int'(parity_upd), (pend_p != pend_old) ? 1 : 0, {pend_tag, " R8 strobe"});
  endtask

  // R11: frame 0 of a window is always sent on the decision edge of the previous one
  task automatic run_window(input string tag, input bit gaps);
    int s_sum = 0, o_sum = 0, c_sum = 0;
    for (int f = 0; f < 16; f++) begin
      if (gaps && f > 0) begin
        int g = $urandom % 3;
        for (int k = 0; k < g; k++) idle_cycle();
      end
      send_frame(w_sent[f], w_ok[f], w_corr[f]);
      s_sum += w_sent[f];
      o_sum += (w_ok[f] > w_sent[f]) ? w_sent[f] : w_ok[f];  // R9
      c_sum += w_corr[f];
      if (pending && f == 0) check_pending();
      if (pending && f == 1) begin
        chk(int'(parity_upd), 0, {pend_tag, " R8 one-cycle strobe"});
        pending = 0;
      end
    end
    pend_old = cur_p;
    pend_p   = exp_next(cur_p, s_sum, o_sum, c_sum);
    cur_p    = pend_p;
    pend_tag = tag;
    pending  = 1;
  endtask

  task automatic fill(input int s, input int o, input int c);
    for (int f = 0; f < 16; f++) begin
      w_sent[f] = s; w_ok[f] = o; w_corr[f] = c;
    end
  endtask

  task automatic fill_random();
    int kind = $urandom % 4;
    for (int f = 0; f < 16; f++) begin
      int s = 1 + $urandom % 32;
      w_sent[f] = s;
      case (kind)
        0: begin w_ok[f] = s; w_corr[f] = $urandom % (s * cur_p / 8 + 1); end
        1: begin w_ok[f] = s - $urandom % (s / 4 + 1); w_corr[f] = $urandom % 64; end
        2: begin w_ok[f] = s; w_corr[f] = $urandom % (s * cur_p / 4 + 2); end
        default: begin w_ok[f] = $urandom % 40; w_corr[f] = $urandom % 1024; end
      endcase
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(int'(parity_syms), 18, "R1 parity in reset");
    chk(int'(parity_upd), 0, "R1 strobe in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(int'(parity_syms), 18, "R1 parity after reset");
    chk(int'(parity_upd), 0, "R1 strobe after reset");

    fill(16, 16, 0);               run_window("R4 clean 18->16", 1);
    fill(16, 15, 0); w_ok[15] = 14; run_window("R5 on threshold hold", 1);
    fill(16, 15, 0); w_ok[15] = 13; run_window("R3 below threshold up", 0);
    fill(16, 0, 0);                run_window("R7 saturate at 18", 1);
    fill(16, 16, 36);              run_window("R4 corr on limit down", 0);
    fill(16, 16, 32); w_corr[0] = 33; run_window("R5 corr over limit hold", 1);
    fill(0, 0, 0);                 run_window("R10 empty window hold", 1);
    fill(10, 200, 0);              run_window("R9 clamp delivered", 0);
    for (int i = 0; i < 7; i++) begin
      fill(20, 20, 1);             run_window("R7 walk to 2 R6", 1);
    end
    for (int i = 0; i < 40; i++) begin
      fill_random();               run_window("R3 R4 random window", ($urandom % 2) == 1);
    end

    idle_cycle();
    check_pending();
    idle_cycle();
    chk(int'(parity_upd), 0, "R8 final strobe low");
    chk(int'(parity_syms), cur_p, "R2 idle no change");

    done = 1;
    summary();
    $finish;
  end

endmodule